// File: doc/BRIEF.md
# Asynchronous Serial Transmit Framer

This block turns one character at a time into an asynchronous serial frame on a single output line. A producer offers a byte with a valid/ready handshake. The framer accepts the byte only while it is idle. It then drives a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Afterwards the line returns to its high idle level.

Bit timing comes from an external baud-tick enable, supplied by a separate rate generator. Each bit lasts a fixed number of ticks: 16 in normal mode and 8 in high-speed mode. The format inputs are static:

- word length, 5 to 8 bits;
- stop-bit count;
- parity: none, even, odd, or a stuck level;
- high-speed mode.

All format inputs are sampled when a character is accepted. A separate break input pulls the line low for as long as it is held. Software that signals a break keeps it asserted for at least two whole frame times.

The block has no character queue, no rate generator and no register access. A surrounding controller provides those.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, txd is high, busy is 0, idle is 1 and in_ready is 1.
- R2: A character is taken only on a clock edge where in_valid and in_ready are both high. in_ready is high only while no frame is in progress. in_valid held high during a frame starts no second frame.
- R3: A frame begins with one low start bit, followed by the data bits least significant first. cfg_wlen selects the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper data bits are never sent.
- R4: With cfg_par_en=1 and cfg_par_stick=0, one parity bit follows the data bits. For cfg_par_even=1 it makes the number of ones among the data bits and parity even. For cfg_par_even=0 it makes that number odd.
- R5: With cfg_par_en=1 and cfg_par_stick=1, the parity bit is 0 when cfg_par_even=1 and 1 when cfg_par_even=0, whatever the data.
- R6: With cfg_par_en=0, no parity bit is sent and the stop bits directly follow the last data bit.
- R7: A frame ends with one high stop bit when cfg_two_stop=0 and two when cfg_two_stop=1.
- R8: Every bit lasts 16 baud ticks when cfg_fast=0 and 8 baud ticks when cfg_fast=1.
- R9: Bit timing advances only on cycles with baud_tick high. Without ticks the frame and the line level hold.
- R10: busy rises on the edge that accepts a character. It falls on the edge that ends the last stop bit. While busy is 0 and there is no break, txd is high.
- R11: While cfg_break is high, txd is low and idle is 0 regardless of frame state. Frame timing continues underneath, and busy still ends at the normal time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable from the rate generator |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Framer can take a character |
| cfg_wlen | input | 2 | Word length code (0..3 = 5..8 bits) |
| cfg_two_stop | input | 1 | Two stop bits when high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity, or stuck level select |
| cfg_par_stick | input | 1 | Parity stuck at a fixed level |
| cfg_fast | input | 1 | 8 ticks per bit instead of 16 |
| cfg_break | input | 1 | Force the line low |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |
| idle | output | 1 | No frame and no break |

## Verification
A corrupted sequencer state or a wrong bit index shows up on txd within one bit time as a misplaced level. It also shows up as a busy fall that comes too early or too late against the bit count the format dictates. A stale captured parity bit or stop count appears only in the last two or three bit windows of the frame. A tick counter with the wrong limit stretches or shrinks every bit, so the mid-bit samples drift out of place by the second data bit.

// File: rtl/txf_pkg.sv
package txf_pkg;

    parameter int TXF_DATA_W = 8;
    localparam int TXF_IDX_W = $clog2(TXF_DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } txf_state_e;

    typedef struct packed {
        txf_state_e              state;
        logic [TXF_DATA_W-1:0]   shreg;
        logic [TXF_IDX_W-1:0]    bit_idx;
        logic [TXF_IDX_W-1:0]    last_idx;
        logic                    stop_idx;
        logic                    two_stop;
        logic                    par_en;
        logic                    par_bit;
        logic                    fast;
        logic                    line;
    } txf_regs_t;

endpackage

// File: rtl/txf_bit_timer.sv
module txf_bit_timer #(
    parameter int SLOW_TICKS = 16,
    parameter int FAST_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic baud_tick,
    input  logic fast,
    output logic bit_done
);
    localparam int CNT_W = $clog2(SLOW_TICKS);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = fast ? FAST_LAST : SLOW_LAST;
        bit_done = baud_tick && (cnt_q == last) && !clear;
        cnt_d    = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (baud_tick) begin
            cnt_d = (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/txf_parity_gen.sv
module txf_parity_gen
    import txf_pkg::*;
(
    input  logic [TXF_DATA_W-1:0] data,
    input  logic [TXF_IDX_W-1:0]  last_idx,
    input  logic                  sel_even,
    input  logic                  stick,
    output logic                  par_bit
);
    logic [TXF_DATA_W-1:0] masked;

    genvar gi;
    generate
        for (gi = 0; gi < TXF_DATA_W; gi++) begin : g_mask
            assign masked[gi] = data[gi] && (TXF_IDX_W'(gi) <= last_idx);
        end
    endgenerate

    always_comb begin
        if (stick) par_bit = !sel_even;
        else       par_bit = sel_even ? ^masked : ~^masked;
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import txf_pkg::*;
#(
    parameter int SLOW_TICKS = 16,
    parameter int FAST_TICKS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  baud_tick,
    input  logic                  in_valid,
    input  logic [TXF_DATA_W-1:0] in_data,
    output logic                  in_ready,
    input  logic [1:0]            cfg_wlen,
    input  logic                  cfg_two_stop,
    input  logic                  cfg_par_en,
    input  logic                  cfg_par_even,
    input  logic                  cfg_par_stick,
    input  logic                  cfg_fast,
    input  logic                  cfg_break,
    output logic                  txd,
    output logic                  busy,
    output logic                  idle
);
    localparam int MIN_WORD = 5;

    txf_regs_t r_d, r_q;
    logic timer_clear;
    logic bit_done;
    logic [TXF_IDX_W-1:0] new_last;
    logic new_par;

    assign new_last = TXF_IDX_W'(cfg_wlen) + TXF_IDX_W'(MIN_WORD - 1);

    txf_parity_gen u_par (
        .data     (in_data),
        .last_idx (new_last),
        .sel_even (cfg_par_even),
        .stick    (cfg_par_stick),
        .par_bit  (new_par)
    );

    txf_bit_timer #(
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (timer_clear),
        .baud_tick (baud_tick),
        .fast      (r_q.fast),
        .bit_done  (bit_done)
    );

    always_comb begin
        r_d         = r_q;
        timer_clear = (r_q.state == ST_IDLE);
        case (r_q.state)
            ST_IDLE: begin
                r_d.line = 1'b1;
                if (in_valid) begin
                    r_d.state    = ST_START;
                    r_d.shreg    = in_data;
                    r_d.last_idx = new_last;
                    r_d.bit_idx  = '0;
                    r_d.stop_idx = 1'b0;
                    r_d.two_stop = cfg_two_stop;
                    r_d.par_en   = cfg_par_en;
                    r_d.par_bit  = new_par;
                    r_d.fast     = cfg_fast;
                    r_d.line     = 1'b0;
                end
            end
            ST_START: begin
                if (bit_done) begin
                    r_d.state = ST_DATA;
                    r_d.line  = r_q.shreg[0];
                    r_d.shreg = r_q.shreg >> 1;
                end
            end
            ST_DATA: begin
                if (bit_done) begin
                    if (r_q.bit_idx == r_q.last_idx) begin
                        if (r_q.par_en) begin
                            r_d.state = ST_PAR;
                            r_d.line  = r_q.par_bit;
                        end else begin
                            r_d.state = ST_STOP;
                            r_d.line  = 1'b1;
                        end
                    end else begin
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        r_d.line    = r_q.shreg[0];
                        r_d.shreg   = r_q.shreg >> 1;
                    end
                end
            end
            ST_PAR: begin
                if (bit_done) begin
                    r_d.state = ST_STOP;
                    r_d.line  = 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_done) begin
                    if (r_q.two_stop && !r_q.stop_idx) begin
                        r_d.stop_idx = 1'b1;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.line  = 1'b1;
                    end
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.line  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.line     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.state == ST_IDLE);
    assign busy     = (r_q.state != ST_IDLE);
    assign idle     = (r_q.state == ST_IDLE) && !cfg_break;
    assign txd      = cfg_break ? 1'b0 : r_q.line;

endmodule

// File: rtl/txf_checker.sv
module txf_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic cfg_break,
    input logic txd,
    input logic busy,
    input logic idle
);
    // R2
    accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R2
    no_accept_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R3
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !cfg_break) |=> (cfg_break || !txd));

    // R10
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_break) |-> txd);

    // R9
    no_tick_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> busy);

    // R9
    no_tick_hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick && !cfg_break) |=> (cfg_break || $stable(txd)));

    // R11
    break_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |-> (!txd && !idle));
endmodule

bind uart_tx_framer txf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cfg_break (cfg_break),
    .txd       (txd),
    .busy      (busy),
    .idle      (idle)
);

// File: tb/uart_tx_framer_test.sv
`timescale 1ns/1ps
module uart_tx_framer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       cfg_fast = 1'b0;
    logic       cfg_break = 1'b0;
    logic       txd, busy, idle;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .cfg_fast(cfg_fast),
        .cfg_break(cfg_break), .txd(txd), .busy(busy), .idle(idle)
    );

    task automatic check(input string req, input logic actual, input logic expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, actual, expected, $time);
        end
    endtask

    // Sends one frame and checks every bit at its middle, plus busy timing.
    task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic ts,
                             input logic pen, input logic pev, input logic pst,
                             input logic fst, input logic hold_valid, input logic brk,
                             input string req);
        logic [15:0] exp_bits;
        int nb;
        int tpb;
        int wbits;
        logic acc;
        exp_bits = '1;
        wbits = int'(wl) + 5;
        tpb = fst ? 8 : 16;
        nb = 0;
        exp_bits[nb] = 1'b0; nb++;
        acc = 1'b0;
        for (int i = 0; i < wbits; i++) begin
            exp_bits[nb] = d[i]; acc ^= d[i]; nb++;
        end
        if (pen) begin
            exp_bits[nb] = pst ? !pev : (pev ? acc : !acc);
            nb++;
        end
        exp_bits[nb] = 1'b1; nb++;
        if (ts) begin exp_bits[nb] = 1'b1; nb++; end

        @(negedge clk);
        cfg_wlen = wl; cfg_two_stop = ts; cfg_par_en = pen;
        cfg_par_even = pev; cfg_par_stick = pst; cfg_fast = fst;
        in_data = d; in_valid = 1'b1;
        @(negedge clk);
        if (hold_valid) in_data = ~d;
        else in_valid = 1'b0;
        check({req, " R2 busy after accept"}, busy, 1'b1);
        check({req, " R2 ready low"}, in_ready, 1'b0);
        for (int m = 1; m <= nb * tpb; m++) begin
            @(negedge clk);
            if (m == nb * tpb - 1) begin
                in_valid = 1'b0;
                check({req, " R10 busy through last stop"}, busy, 1'b1);
            end
            if ((m % tpb) == tpb / 2) begin
                check($sformatf("%s R3/R8 bit %0d", req, m / tpb), txd,
                      brk ? 1'b0 : exp_bits[m / tpb]);
            end
        end
        check({req, " R10 busy falls at end"}, busy, 1'b0);
        check({req, " R10 line idle"}, txd, !brk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 txd", txd, 1'b1);
        check("R1 busy", busy, 1'b0);
        check("R1 idle", idle, 1'b1);
        check("R1 in_ready", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_word_lengths();
        run_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 8N1");
        run_frame(8'hF3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 5N1");
        run_frame(8'h6C, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 6N1");
        run_frame(8'h95, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 7N1");
    endtask

    task automatic t_parity();
        run_frame(8'h07, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 even");
        run_frame(8'h07, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 odd");
        run_frame(8'hE1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 even 5bit");
        run_frame(8'hFF, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 stick zero");
        run_frame(8'h00, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 stick one");
    endtask

    task automatic t_stop_and_speed();
        run_frame(8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 two stop");
        run_frame(8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 fast 8O2");
    endtask

    task automatic t_valid_while_busy();
        run_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 hold valid");
        repeat (30) @(negedge clk);
        check("R2 no second frame busy", busy, 1'b0);
        check("R2 no second frame line", txd, 1'b1);
    endtask

    task automatic t_no_tick();
        @(negedge clk);
        cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; cfg_fast = 1'b0;
        in_data = 8'hFF; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        baud_tick = 1'b0;
        repeat (60) @(negedge clk);
        check("R9 busy held", busy, 1'b1);
        check("R9 start bit held", txd, 1'b0);
        baud_tick = 1'b1;
        repeat (14) @(negedge clk);
        check("R9 start continues", txd, 1'b0);
        repeat (4) @(negedge clk);
        check("R9 first data bit", txd, 1'b1);
        repeat (10 * 16) @(negedge clk);
        check("R9 finished", busy, 1'b0);
    endtask

    task automatic t_break();
        @(negedge clk);
        cfg_break = 1'b1;
        @(negedge clk);
        check("R11 idle line low", txd, 1'b0);
        check("R11 idle flag low", idle, 1'b0);
        check("R11 not busy", busy, 1'b0);
        run_frame(8'hFF, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R11 frame under break");
        cfg_break = 1'b0;
        @(negedge clk);
        check("R11 release line", txd, 1'b1);
        check("R11 release idle", idle, 1'b1);
    endtask

    initial begin
        t_reset();
        t_word_lengths();
        t_parity();
        t_stop_and_speed();
        t_valid_while_busy();
        t_no_tick();
        t_break();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule